// File: doc/BRIEF.md
# E1 Receive Change-Event Interrupt Controller

This block sits beside an E1 receive framer and turns its status indications into one maskable interrupt line. It watches four kinds of change: a change of FAS framing position, a change in the received national bits Sa4 to Sa8, a toggle of the loss-of-CAS-multiframe flag in either direction, and a change of the ABCD signaling nibble on any of the 30 signaling channels. The framer supplies a strobe for each frame and a separate strobe for each received signaling nibble. The block does not search for frame or multiframe alignment itself.

Each event sets a sticky status bit, whether or not its interrupt is enabled. The interrupt output is high while any status bit is set and its enable bit is also set. Software reads the status register to learn which event occurred, and the read clears it. Software reads the channel-flag bytes to learn which signaling channels changed. Each of those reads clears only the flags it returned. Reference values for the Sa bits and for each channel's nibble load silently from the first qualifying strobe, so that coming back into alignment does not produce a false change.

Top module: `e1rx_event_irq`

## Requirements
- R1: After reset the enable register, the status register, every channel flag and `irq` are all 0.
- R2: Address 0 is a read/write enable register. Bit 7 enables the multiframe event, bit 6 the national-bit event, bit 5 the signaling event and bit 4 the FAS event. `irq` is high exactly while some status bit in 7:4 and its enable bit are both 1.
- R3: On each `frm_stb`, if `mf_lost` differs from its value at the previous `frm_stb`, status bit 7 is set. Before the first strobe after reset, the previous value is taken to be 1 (multiframe lost).
- R4: `frm_stb` together with `fas_moved` sets status bit 4.
- R5: A `frm_stb` with `frm_aligned` low discards the Sa reference and raises no event. The next aligned strobe loads `sa_bits` as the reference without an event. After that, an aligned strobe whose `sa_bits` differ from the reference sets status bit 6 and updates the reference.
- R6: A `sig_stb` with `cas_on` high and `mf_lost` low compares `sig_abcd` with the stored nibble of channel `sig_ch`. The first strobe after reset or after invalidation loads the nibble silently. A later difference sets that channel's flag and status bit 5. A `sig_ch` of 30 or more is ignored.
- R7: While `cas_on` or `mf_lost` disables comparison, no signaling flag or status bit 5 is set and all stored nibbles are invalidated.
- R8: Channel c's flag is readable at address 2 + c/8, bit c mod 8. Unused bits read as 0.
- R9: A read of address 1 returns, on the next cycle, the status held before the read in bits 7:4 with bits 3:0 at 0, and then clears it. An event in the same cycle as the read stays set.
- R10: A read of a flag byte clears only the flags in that byte. A channel change in the same cycle as the read stays set.
- R11: Status bits are set even while their enable is 0. Setting the enable later raises `irq` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle strobe per received frame carrying Sa bits |
| frm_aligned | input | 1 | Framer currently holds FAS alignment |
| fas_moved | input | 1 | FAS position changed, qualified by `frm_stb` |
| mf_lost | input | 1 | Loss of CAS multiframe alignment (level) |
| sa_bits | input | 5 | Received Sa4..Sa8 |
| sig_stb | input | 1 | Strobe for one received signaling nibble |
| sig_ch | input | 5 | Signaling channel index 0..29 |
| sig_abcd | input | 4 | Received ABCD nibble |
| cas_on | input | 1 | Channel associated signaling in use |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request |

## Verification
A clear-on-read and a new event can land in the same clock cycle, for both the status register and a channel-flag byte. The bench provokes this by raising a `fas_moved` frame strobe in the cycle of a status read, and a signaling change on a second channel in the cycle of a flag-byte read. In each case the read must return only the earlier contents. The follow-up read must show the new event still set.

// File: rtl/e1evt_pkg.sv
package e1evt_pkg;
   localparam int unsigned BIT_MF  = 7;
   localparam int unsigned BIT_NAT = 6;
   localparam int unsigned BIT_SIG = 5;
   localparam int unsigned BIT_FAS = 4;
   localparam int unsigned ADR_EN  = 0;
   localparam int unsigned ADR_ST  = 1;
   localparam int unsigned ADR_FLG = 2;

   typedef struct packed {
      logic mf;
      logic nat;
      logic sig;
      logic fas;
   } evt_t;
endpackage

// File: rtl/e1evt_change_det.sv
module e1evt_change_det #(
   parameter int unsigned W           = 5,
   parameter bit          START_VALID = 1'b0,
   parameter logic [W-1:0] RST_VAL    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic         ok,
   input  logic [W-1:0] din,
   output logic         evt
);
   logic [W-1:0] ref_q;
   logic         ref_ok;

   generate
      if (W < 1) begin : g_bad_w
         $error("e1evt_change_det: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q  <= RST_VAL;
         ref_ok <= START_VALID;
      end else if (stb) begin
         if (!ok) begin
            ref_ok <= 1'b0;
         end else begin
            ref_q  <= din;
            ref_ok <= 1'b1;
         end
      end
   end

   assign evt = stb && ok && ref_ok && (din != ref_q);

   a_r5_first_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && ok && !ref_ok) |-> !evt);
endmodule

// File: rtl/e1evt_sig_map.sv
module e1evt_sig_map #(
   parameter int unsigned N_CH  = 30,
   parameter int unsigned SIG_W = 4,
   parameter int unsigned CW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic [CW-1:0]    ch,
   input  logic [SIG_W-1:0] abcd,
   input  logic             cas_on,
   input  logic             mf_ok,
   input  logic [N_CH-1:0]  clr_mask,
   output logic [N_CH-1:0]  flags,
   output logic             evt
);
   logic [N_CH-1:0] chg;
   logic            cmp_on;

   assign cmp_on = cas_on && mf_ok;

   generate
      if ((1 << CW) < N_CH) begin : g_bad_cw
         $error("e1evt_sig_map: CW too narrow for N_CH");
      end
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         logic [SIG_W-1:0] ref_q;
         logic             ref_ok;
         logic             hit;
         assign hit    = stb && cmp_on && (ch == CW'(c));
         assign chg[c] = hit && ref_ok && (abcd != ref_q);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ref_q  <= '0;
               ref_ok <= 1'b0;
            end else if (!cmp_on) begin
               ref_ok <= 1'b0;
            end else if (hit) begin
               ref_q  <= abcd;
               ref_ok <= 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_mask) | chg;
   end

   assign evt = |chg;

   a_r7_no_sig_without_cas: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_on |-> !evt);
   a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|clr_mask) && !evt) |=> $stable(flags));
endmodule

// File: rtl/e1evt_regs.sv
module e1evt_regs
   import e1evt_pkg::*;
#(
   parameter int unsigned N_CH = 30,
   parameter int unsigned AW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            rd_en,
   input  logic [AW-1:0]   addr,
   input  logic [7:0]      wdata,
   input  evt_t            evt,
   input  logic [N_CH-1:0] flags,
   output logic [N_CH-1:0] flag_clr,
   output logic [7:0]      rdata,
   output logic            irq
);
   localparam int unsigned NB  = (N_CH + 7) / 8;
   localparam int unsigned PAD = NB * 8;

   logic [7:0]     en_q;
   evt_t           st_q;
   logic           st_rd;
   logic [PAD-1:0] flag_pad;
   logic [7:0]     flag_byte [NB];

   generate
      if (ADR_FLG + NB > (1 << AW)) begin : g_bad_aw
         $error("e1evt_regs: address space too small for flag bytes");
      end
      if (N_CH < 1) begin : g_bad_n
         $error("e1evt_regs: N_CH must be at least 1");
      end
      for (genvar b = 0; b < NB; b++) begin : g_byte
         assign flag_byte[b] = flag_pad[b*8 +: 8];
      end
      for (genvar c = 0; c < N_CH; c++) begin : g_clr
         assign flag_clr[c] = rd_en && (addr == AW'(ADR_FLG + c / 8));
      end
   endgenerate

   assign flag_pad = PAD'(flags);
   assign st_rd    = rd_en && (addr == AW'(ADR_ST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
         st_q <= '0;
      end else begin
         if (wr_en && (addr == AW'(ADR_EN))) en_q <= wdata;
         st_q <= (st_rd ? evt_t'('0) : st_q) | evt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= '0;
         if (addr == AW'(ADR_EN)) begin
            rdata <= en_q;
         end else if (addr == AW'(ADR_ST)) begin
            rdata <= {st_q, 4'b0000};
         end else begin
            for (int b = 0; b < NB; b++) begin
               if (addr == AW'(ADR_FLG + b)) rdata <= flag_byte[b];
            end
         end
      end
   end

   assign irq = (st_q.mf  && en_q[BIT_MF])  ||
                (st_q.nat && en_q[BIT_NAT]) ||
                (st_q.sig && en_q[BIT_SIG]) ||
                (st_q.fas && en_q[BIT_FAS]);

   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && (evt == '0)) |=> (st_q == '0));
   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !st_rd |=> ((st_q & $past(st_q)) == $past(st_q)));
   a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|en_q[7:4]));
endmodule

// File: rtl/e1rx_event_irq.sv
module e1rx_event_irq
   import e1evt_pkg::*;
#(
   parameter int unsigned N_CH  = 30,
   parameter int unsigned SA_W  = 5,
   parameter int unsigned SIG_W = 4,
   parameter int unsigned CW    = 5,
   parameter int unsigned AW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_stb,
   input  logic             frm_aligned,
   input  logic             fas_moved,
   input  logic             mf_lost,
   input  logic [SA_W-1:0]  sa_bits,
   input  logic             sig_stb,
   input  logic [CW-1:0]    sig_ch,
   input  logic [SIG_W-1:0] sig_abcd,
   input  logic             cas_on,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic             irq
);
   evt_t            evt;
   logic [N_CH-1:0] flags;
   logic [N_CH-1:0] flag_clr;

   e1evt_change_det #(.W(1), .START_VALID(1'b1), .RST_VAL(1'b1)) u_mf (
      .clk(clk), .rst_n(rst_n), .stb(frm_stb), .ok(1'b1),
      .din(mf_lost), .evt(evt.mf));

   e1evt_change_det #(.W(SA_W), .START_VALID(1'b0), .RST_VAL('0)) u_sa (
      .clk(clk), .rst_n(rst_n), .stb(frm_stb), .ok(frm_aligned),
      .din(sa_bits), .evt(evt.nat));

   assign evt.fas = frm_stb && fas_moved;

   e1evt_sig_map #(.N_CH(N_CH), .SIG_W(SIG_W), .CW(CW)) u_sig (
      .clk(clk), .rst_n(rst_n), .stb(sig_stb), .ch(sig_ch), .abcd(sig_abcd),
      .cas_on(cas_on), .mf_ok(!mf_lost), .clr_mask(flag_clr),
      .flags(flags), .evt(evt.sig));

   e1evt_regs #(.N_CH(N_CH), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .evt(evt), .flags(flags), .flag_clr(flag_clr),
      .rdata(rdata), .irq(irq));

   a_r4_fas_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_stb && fas_moved) |=> (u_regs.st_q.fas));
endmodule

// File: tb/e1rx_event_irq_test.sv
module e1rx_event_irq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_stb = 0, frm_aligned = 0, fas_moved = 0, mf_lost = 1;
   logic [4:0] sa_bits = '0;
   logic       sig_stb = 0;
   logic [4:0] sig_ch = '0;
   logic [3:0] sig_abcd = '0;
   logic       cas_on = 1;
   logic       wr_en = 0, rd_en = 0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_pend = 0;
   bit         done = 0;

   always #4 clk = ~clk;

   e1rx_event_irq uut (
      .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_aligned(frm_aligned),
      .fas_moved(fas_moved), .mf_lost(mf_lost), .sa_bits(sa_bits),
      .sig_stb(sig_stb), .sig_ch(sig_ch), .sig_abcd(sig_abcd), .cas_on(cas_on),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq));

   always @(posedge clk) rd_pend <= rd_en;

   // monitor: pops the scoreboard when read data becomes valid
   always @(negedge clk) begin
      if (rd_pend && exp_q.size() > 0) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
         end
      end
   end

   task automatic chk_irq(input logic e, input string t);
      n_chk++;
      if (irq !== e) begin
         n_fail++;
         $display("FAIL %s: irq=%b expected=%b", t, irq, e);
      end
   endtask

   task automatic idle();
      frm_stb = 0; fas_moved = 0; sig_stb = 0; wr_en = 0; rd_en = 0;
   endtask

   // driver: issue a read, push expectation; strobes set beforehand ride along
   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
      rd_en = 1; addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk); idle();
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk); idle();
   endtask

   task automatic frame(input logic al, input logic mv, input logic ml, input logic [4:0] sa);
      frm_stb = 1; frm_aligned = al; fas_moved = mv; mf_lost = ml; sa_bits = sa;
      @(negedge clk); idle();
   endtask

   task automatic sig(input int ch, input logic [3:0] v);
      sig_stb = 1; sig_ch = 5'(ch); sig_abcd = v;
      @(negedge clk); idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk_irq(0, "R1 irq after reset");
      rd(0, 8'h00, "R1 enable reset");
      rd(1, 8'h00, "R1 status reset");
      for (int b = 2; b < 6; b++) rd(3'(b), 8'h00, "R1 flags reset");
      // R2 enable read/write
      wr(0, 8'hF0);
      rd(0, 8'hF0, "R2 enable readback");
      wr(0, 8'h00);
      // R3/R5 first Sa strobe loads silently, mf still lost
      frame(1, 0, 1, 5'h15);
      rd(1, 8'h00, "R5 silent Sa load");
      frame(1, 0, 1, 5'h15);
      frame(1, 0, 1, 5'h14);
      rd(1, 8'h40, "R5 Sa change");
      rd(1, 8'h00, "R9 status cleared");
      // R3 both edges of mf_lost
      frame(1, 0, 0, 5'h14);
      rd(1, 8'h80, "R3 mf regained");
      frame(1, 0, 1, 5'h14);
      rd(1, 8'h80, "R3 mf lost");
      frame(1, 0, 1, 5'h14);
      rd(1, 8'h00, "R3 no toggle");
      // R4 FAS move
      frame(1, 1, 1, 5'h14);
      rd(1, 8'h10, "R4 fas moved");
      // R11 masked sticky then enable
      frame(1, 1, 1, 5'h14);
      chk_irq(0, "R11 masked event");
      wr(0, 8'h10);
      chk_irq(1, "R11 late enable");
      rd(1, 8'h10, "R11 status held");
      chk_irq(0, "R2 irq after clear");
      // R5 alignment loss invalidates Sa reference
      frame(0, 0, 1, 5'h00);
      frame(1, 0, 1, 5'h1F);
      rd(1, 8'h00, "R5 reload after realign");
      // R6 signaling map
      frame(1, 0, 0, 5'h1F);
      rd(1, 8'h80, "R3 mf regained again");
      for (int c = 0; c < 30; c++) sig(c, 4'(c));
      sig(30, 4'hF);
      rd(1, 8'h00, "R6 silent nibble load");
      sig(0, 4'hA); sig(9, 4'h0); sig(29, 4'h0); sig(30, 4'h3);
      rd(2, 8'h01, "R8 ch0 flag");
      rd(3, 8'h02, "R8 ch9 flag");
      rd(4, 8'h00, "R8 byte2 clean");
      rd(5, 8'h20, "R8 ch29 flag");
      rd(1, 8'h20, "R6 sig status");
      rd(2, 8'h00, "R10 byte cleared");
      // R10 same-cycle change during flag read
      sig(1, 4'h0);
      sig_stb = 1; sig_ch = 5'd2; sig_abcd = 4'h0;
      rd(2, 8'h02, "R10 read with concurrent change");
      rd(2, 8'h04, "R10 concurrent change kept");
      // R9 same-cycle event during status read
      frm_stb = 1; frm_aligned = 1; fas_moved = 1; mf_lost = 0; sa_bits = 5'h1F;
      rd(1, 8'h20, "R9 read with concurrent event");
      rd(1, 8'h10, "R9 concurrent event kept");
      // R7 CAS off suppresses and invalidates
      wr(0, 8'h20);
      cas_on = 0;
      sig(3, 4'h0);
      chk_irq(0, "R7 no irq with cas off");
      rd(2, 8'h00, "R7 no flag with cas off");
      rd(1, 8'h00, "R7 no status with cas off");
      cas_on = 1;
      sig(3, 4'h5);
      rd(1, 8'h00, "R7 silent reload after cas on");
      sig(3, 4'h6);
      chk_irq(1, "R2 sig irq enabled");
      rd(2, 8'h08, "R6 ch3 flag");
      rd(1, 8'h20, "R6 status after ch3");
      chk_irq(0, "R9 irq after read");
      @(negedge clk);
      finish_run();
   end
endmodule